// File: doc/BRIEF.md
# Overlapped Head/Tail Issue Controller

This block is the timing and interlock controller of a floating-point coprocessor with eight register indices. Each instruction arrives on a valid/ready port with an operation class, one source index, one destination index, a tag and a serialize flag. The controller splits the instruction into two phases. The first is a front-end phase, which covers conversion and bus work. The second is an execution phase, which holds the single arithmetic unit. Each phase lasts a fixed number of cycles that depends on the class.

While the arithmetic unit finishes one instruction, the front end can already work on the next one. A later instruction that reads a register an earlier one is still producing must wait until that earlier instruction has retired. A register move has no execution phase, so it can complete while an arithmetic operation is still running and cost nothing. An instruction flagged as serializing waits until the pipeline is empty. The block carries no data; it only sequences the instructions and reports, by tag, when each one issues and when each one completes.

Top module: `ovl_issue_ctrl`

## Requirements
- R1: A synchronous active-high reset empties both phases and clears every pending register. After reset `in_ready` is 1 and neither pulse is asserted. An instruction that was in flight at reset never produces a completion pulse.
- R2: When `in_valid` and `in_ready` are both 1 at a clock edge, the instruction is accepted. `issue_pulse` is then high for exactly the following cycle, carrying the accepted tag.
- R3: Each class costs a fixed front-end/execution length in cycles. The class codes are: 0 add 17/35, 1 subtract 17/35, 2 multiply 17/55, 3 divide 17/87, 4 square root 17/89, 5 move 21/0. Codes 6 and 7 cost the same as add. With the pipeline empty, the completion pulse comes front-end plus execution cycles after the issue pulse.
- R4: There is one front-end slot. The next independent instruction is accepted at the same edge at which the current front-end phase hands off, which is 17 cycles after an arithmetic issue. An instruction whose front-end phase is done waits for the arithmetic unit, and it starts execution at the same edge at which the previous execution ends.
- R5: If `in_src` equals the destination of an instruction still in flight, `in_ready` is 0. The instruction is accepted at the same edge that retires the producer, so its issue pulse coincides with the producer's completion pulse.
- R6: A move (code 5) never uses the arithmetic unit. It completes as soon as its 21-cycle front-end phase ends, even while an arithmetic instruction is executing.
- R7: When `in_drain` is 1, the instruction is accepted only while nothing is in flight. Its issue pulse therefore comes one cycle after the last completion pulse.
- R8: Each instruction gives exactly one `done_pulse` cycle, carrying its tag. If a move would finish in the same cycle that an execution phase ends, the move completes one cycle later.
- R9: `cycle_count` is 0 during reset and increases by one at every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_cls | input | 3 | Operation class code |
| in_src | input | 3 | Source register index |
| in_dst | input | 3 | Destination register index |
| in_drain | input | 1 | Wait for an empty pipeline before acceptance |
| in_tag | input | TAG_W | Instruction tag |
| issue_pulse | output | 1 | One-cycle acceptance report |
| issue_tag | output | TAG_W | Tag of the issued instruction |
| done_pulse | output | 1 | One-cycle completion report |
| done_tag | output | TAG_W | Tag of the completed instruction |
| cycle_count | output | CNT_W | Free-running cycle counter |

## Verification
Single instructions of each class, sent into an empty pipeline, pin down the phase lengths without any overlap. Pairs of arithmetic operations are run two ways: with independent registers, and with the second instruction reading the first one's result. Comparing the two separates the overlapped spacing of 17 cycles from the fully serialized spacing. A chain of three multiplies checks that execution phases follow each other with no gap. Moves are placed after an add in three ways: independent of it, dependent on it, and timed so that the move would finish in the same cycle the add completes. These show the hidden move, the serialized move and the one-cycle deferral, and a serializing instruction and a reset during an operation cover emptying the pipeline.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_SQRT = 3'd4,
    OP_MOV  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_cls_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ovl_cost.sv
module ovl_cost import ovl_pkg::*; #(
  parameter int unsigned HEAD_ARITH = 17,
  parameter int unsigned HEAD_MOVE  = 21,
  parameter int unsigned TAIL_ADD   = 35,
  parameter int unsigned TAIL_MUL   = 55,
  parameter int unsigned TAIL_DIV   = 87,
  parameter int unsigned TAIL_SQRT  = 89,
  parameter int unsigned CW         = 7
) (
  input  op_cls_e         cls,
  output logic [CW-1:0]   head_len,
  output logic [CW-1:0]   tail_len
);
  function automatic logic [CW-1:0] head_of(input op_cls_e c);
    return (c == OP_MOV) ? CW'(HEAD_MOVE) : CW'(HEAD_ARITH);
  endfunction

  function automatic logic [CW-1:0] tail_of(input op_cls_e c);
    case (c)
      OP_MUL:  return CW'(TAIL_MUL);
      OP_DIV:  return CW'(TAIL_DIV);
      OP_SQRT: return CW'(TAIL_SQRT);
      OP_MOV:  return '0;
      default: return CW'(TAIL_ADD);
    endcase
  endfunction

  assign head_len = head_of(cls);
  assign tail_len = tail_of(cls);
endmodule

// File: rtl/ovl_head_slot.sv
module ovl_head_slot #(
  parameter int unsigned CW = 7,
  parameter int unsigned RW = 3,
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_head,
  input  logic [CW-1:0] load_tail,
  input  logic [RW-1:0] load_dst,
  input  logic [TW-1:0] load_tag,
  input  logic          handoff,
  output logic          busy,
  output logic          fin,
  output logic [CW-1:0] tail_len,
  output logic [RW-1:0] dst,
  output logic [TW-1:0] tag
);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      left     <= '0;
      tail_len <= '0;
      dst      <= '0;
      tag      <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      left     <= load_head - 1'b1;
      tail_len <= load_tail;
      dst      <= load_dst;
      tag      <= load_tag;
    end else if (handoff) begin
      busy <= 1'b0;
    end else if (busy && left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign fin = busy && (left == '0);
endmodule

// File: rtl/ovl_tail_slot.sv
module ovl_tail_slot #(
  parameter int unsigned CW = 7,
  parameter int unsigned RW = 3,
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] start_len,
  input  logic [RW-1:0] start_dst,
  input  logic [TW-1:0] start_tag,
  output logic          busy,
  output logic          last,
  output logic [RW-1:0] dst,
  output logic [TW-1:0] tag
);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
      dst  <= '0;
      tag  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      left <= start_len - 1'b1;
      dst  <= start_dst;
      tag  <= start_tag;
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end

  assign last = busy && (left == '0);
endmodule

// File: rtl/ovl_hazard.sv
module ovl_hazard #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned RW       = 3
) (
  input  logic          h_busy,
  input  logic [RW-1:0] h_dst,
  input  logic          h_retire,
  input  logic          t_busy,
  input  logic [RW-1:0] t_dst,
  input  logic          t_retire,
  input  logic [RW-1:0] src,
  output logic          conflict
);
  logic [NUM_REGS-1:0] live;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic by_head, by_tail;
    assign by_head = h_busy && !h_retire && (h_dst == RW'(r));
    assign by_tail = t_busy && !t_retire && (t_dst == RW'(r));
    assign live[r] = by_head || by_tail;
  end

  assign conflict = live[src];
endmodule

// File: rtl/ovl_issue_ctrl.sv
module ovl_issue_ctrl import ovl_pkg::*; #(
  parameter int unsigned NUM_REGS   = 8,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned HEAD_ARITH = 17,
  parameter int unsigned HEAD_MOVE  = 21,
  parameter int unsigned TAIL_ADD   = 35,
  parameter int unsigned TAIL_MUL   = 55,
  parameter int unsigned TAIL_DIV   = 87,
  parameter int unsigned TAIL_SQRT  = 89
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [2:0]                  in_cls,
  input  logic [$clog2(NUM_REGS)-1:0] in_src,
  input  logic [$clog2(NUM_REGS)-1:0] in_dst,
  input  logic                        in_drain,
  input  logic [TAG_W-1:0]            in_tag,
  output logic                        issue_pulse,
  output logic [TAG_W-1:0]            issue_tag,
  output logic                        done_pulse,
  output logic [TAG_W-1:0]            done_tag,
  output logic [CNT_W-1:0]            cycle_count
);
  localparam int unsigned RW = $clog2(NUM_REGS);
  localparam int unsigned MAXC = max_u(max_u(HEAD_ARITH, HEAD_MOVE),
                                       max_u(max_u(TAIL_ADD, TAIL_MUL),
                                             max_u(TAIL_DIV, TAIL_SQRT)));
  localparam int unsigned CW = $clog2(MAXC + 1);

  logic [CW-1:0]    c_head, c_tail;
  logic             h_busy, h_fin;
  logic [CW-1:0]    h_tail;
  logic [RW-1:0]    h_dst;
  logic [TAG_W-1:0] h_tag;
  logic             t_busy, tail_last;
  logic [RW-1:0]    t_dst;
  logic [TAG_W-1:0] t_tag;
  logic             mv_fin, tail_go, handoff, head_free, conflict, accept;

  ovl_cost #(
    .HEAD_ARITH(HEAD_ARITH), .HEAD_MOVE(HEAD_MOVE), .TAIL_ADD(TAIL_ADD),
    .TAIL_MUL(TAIL_MUL), .TAIL_DIV(TAIL_DIV), .TAIL_SQRT(TAIL_SQRT), .CW(CW)
  ) u_cost (
    .cls(op_cls_e'(in_cls)), .head_len(c_head), .tail_len(c_tail)
  );

  ovl_head_slot #(.CW(CW), .RW(RW), .TW(TAG_W)) u_head (
    .clk(clk), .rst(rst), .load(accept), .load_head(c_head), .load_tail(c_tail),
    .load_dst(in_dst), .load_tag(in_tag), .handoff(handoff),
    .busy(h_busy), .fin(h_fin), .tail_len(h_tail), .dst(h_dst), .tag(h_tag)
  );

  ovl_tail_slot #(.CW(CW), .RW(RW), .TW(TAG_W)) u_tail (
    .clk(clk), .rst(rst), .start(tail_go), .start_len(h_tail),
    .start_dst(h_dst), .start_tag(h_tag),
    .busy(t_busy), .last(tail_last), .dst(t_dst), .tag(t_tag)
  );

  ovl_hazard #(.NUM_REGS(NUM_REGS), .RW(RW)) u_haz (
    .h_busy(h_busy), .h_dst(h_dst), .h_retire(mv_fin),
    .t_busy(t_busy), .t_dst(t_dst), .t_retire(tail_last),
    .src(in_src), .conflict(conflict)
  );

  // A zero-length execution phase retires from the front-end slot, unless
  // the arithmetic unit retires in the same cycle (one completion per cycle).
  assign mv_fin    = h_fin && (h_tail == '0) && !tail_last;
  assign tail_go   = h_fin && (h_tail != '0) && (!t_busy || tail_last);
  assign handoff   = mv_fin || tail_go;
  assign head_free = !h_busy || handoff;
  assign in_ready  = in_drain ? (!h_busy && !t_busy) : (head_free && !conflict);
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_pulse <= 1'b0;
      issue_tag   <= '0;
      done_pulse  <= 1'b0;
      done_tag    <= '0;
      cycle_count <= '0;
    end else begin
      issue_pulse <= accept;
      issue_tag   <= in_tag;
      done_pulse  <= tail_last || mv_fin;
      done_tag    <= tail_last ? t_tag : h_tag;
      cycle_count <= cycle_count + 1'b1;
    end
  end
endmodule

// File: rtl/ovl_issue_chk.sv
module ovl_issue_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_drain,
  input logic             issue_pulse,
  input logic             done_pulse,
  input logic             h_busy,
  input logic             t_busy,
  input logic             tail_last,
  input logic             mv_fin,
  input logic             conflict,
  input logic [CNT_W-1:0] cycle_count
);
  p_issue_accept_r2: assert property (@(posedge clk) disable iff (rst)
    issue_pulse |-> $past(in_valid && in_ready));

  p_tail_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (t_busy && !tail_last) |=> t_busy);

  p_conflict_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_drain && conflict) |-> !in_ready);

  p_drain_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_drain && in_ready) |-> (!h_busy && !t_busy));

  p_done_source_r8: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> $past(tail_last || mv_fin));

  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cycle_count == $past(cycle_count) + 1'b1);
endmodule

bind ovl_issue_ctrl ovl_issue_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_drain(in_drain), .issue_pulse(issue_pulse), .done_pulse(done_pulse),
  .h_busy(h_busy), .t_busy(t_busy), .tail_last(tail_last), .mv_fin(mv_fin),
  .conflict(conflict), .cycle_count(cycle_count)
);

// File: tb/ovl_issue_ctrl_tb.sv
module ovl_issue_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_cls = '0;
  logic [2:0]  in_src = '0;
  logic [2:0]  in_dst = '0;
  logic        in_drain = 1'b0;
  logic [3:0]  in_tag = '0;
  logic        issue_pulse, done_pulse;
  logic [3:0]  issue_tag, done_tag;
  logic [31:0] cycle_count;

  int tb_cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int iss_at[16];
  int don_at[16];

  always #4 clk = ~clk;

  ovl_issue_ctrl u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_src(in_src), .in_dst(in_dst), .in_drain(in_drain),
    .in_tag(in_tag), .issue_pulse(issue_pulse), .issue_tag(issue_tag),
    .done_pulse(done_pulse), .done_tag(done_tag), .cycle_count(cycle_count)
  );

  always @(posedge clk) tb_cyc <= tb_cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (issue_pulse) iss_at[issue_tag] = tb_cyc;
      if (done_pulse) begin
        don_at[done_tag] = tb_cyc;
        done_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    if (tb_cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", tb_cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    done_cnt = 0;
    for (int i = 0; i < 16; i++) begin
      iss_at[i] = -1;
      don_at[i] = -1;
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [2:0] s, input logic [2:0] d,
                      input logic dr, input logic [3:0] t);
    @(negedge clk);
    in_valid = 1'b1; in_cls = c; in_src = s; in_dst = d; in_drain = dr; in_tag = t;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0; in_drain = 1'b0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // R1, R9: reset state and counter
  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready in reset", int'(in_ready), 1);
    chk("R1 issue in reset", int'(issue_pulse), 0);
    chk("R1 done in reset", int'(done_pulse), 0);
    chk("R9 count in reset", int'(cycle_count), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 count after 5 edges", int'(cycle_count), 5);
  endtask

  // R3: isolated latency per class
  task automatic t_single(input logic [2:0] c, input int exp, input string req);
    clear_log();
    send(c, 3'd0, 3'd1, 1'b0, 4'd5);
    wait_done(1);
    chk(req, don_at[5] - iss_at[5], exp);
    chk("R2 issue tag seen", int'(iss_at[5] >= 0), 1);
  endtask

  // R4: independent pair overlaps
  task automatic t_indep();
    clear_log();
    send(3'd0, 3'd0, 3'd1, 1'b0, 4'd1);
    send(3'd0, 3'd2, 3'd3, 1'b0, 4'd2);
    wait_done(2);
    chk("R4 indep issue spacing", iss_at[2] - iss_at[1], 17);
    chk("R4 indep second done", don_at[2] - iss_at[1], 87);
  endtask

  // R5: dependent pair serializes
  task automatic t_dep();
    clear_log();
    send(3'd0, 3'd0, 3'd1, 1'b0, 4'd1);
    @(negedge clk);
    in_valid = 1'b1; in_cls = 3'd0; in_src = 3'd1; in_dst = 3'd2; in_tag = 4'd2;
    repeat (20) @(negedge clk);
    chk("R5 ready low on conflict", int'(in_ready), 0);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    wait_done(2);
    chk("R5 dep issue spacing", iss_at[2] - iss_at[1], 52);
    chk("R5 issue with producer done", iss_at[2] - don_at[1], 0);
    chk("R5 dep second done", don_at[2] - iss_at[1], 104);
  endtask

  // R6: move hidden / move serialized
  task automatic t_move(input logic [2:0] msrc, input int exp_iss, input int exp_done,
                        input string req);
    clear_log();
    send(3'd0, 3'd0, 3'd1, 1'b0, 4'd1);
    send(3'd5, msrc, 3'd4, 1'b0, 4'd2);
    wait_done(2);
    chk({req, " issue"}, iss_at[2] - iss_at[1], exp_iss);
    chk({req, " done"}, don_at[2] - iss_at[1], exp_done);
    chk("R6 add done unchanged", don_at[1] - iss_at[1], 52);
  endtask

  // R8: move finishing with tail completion is deferred one cycle
  task automatic t_collide();
    clear_log();
    send(3'd0, 3'd0, 3'd1, 1'b0, 4'd1);
    repeat (30) @(posedge clk);
    send(3'd5, 3'd2, 3'd3, 1'b0, 4'd2);
    wait_done(2);
    chk("R8 move issue offset", iss_at[2] - iss_at[1], 31);
    chk("R8 add done", don_at[1] - iss_at[1], 52);
    chk("R8 move deferred done", don_at[2] - iss_at[1], 53);
    chk("R8 one pulse each", done_cnt, 2);
  endtask

  // R4: chained multiplies keep the arithmetic unit busy
  task automatic t_chain();
    clear_log();
    send(3'd2, 3'd4, 3'd1, 1'b0, 4'd1);
    send(3'd2, 3'd5, 3'd2, 1'b0, 4'd2);
    send(3'd2, 3'd6, 3'd3, 1'b0, 4'd3);
    wait_done(3);
    chk("R4 chain second issue", iss_at[2] - iss_at[1], 17);
    chk("R4 chain third issue", iss_at[3] - iss_at[1], 72);
    chk("R4 chain first done", don_at[1] - iss_at[1], 72);
    chk("R4 chain third done", don_at[3] - iss_at[1], 182);
  endtask

  // R7: serializing instruction waits for empty pipeline
  task automatic t_drain();
    clear_log();
    send(3'd0, 3'd0, 3'd1, 1'b0, 4'd1);
    send(3'd0, 3'd5, 3'd6, 1'b1, 4'd2);
    wait_done(2);
    chk("R7 drain issue after done", iss_at[2] - don_at[1], 1);
    chk("R7 drain latency", don_at[2] - iss_at[2], 52);
  endtask

  // R1: reset in flight discards the instruction
  task automatic t_reset_mid();
    clear_log();
    send(3'd3, 3'd0, 3'd1, 1'b0, 4'd7);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    done_cnt = 0;
    repeat (120) @(negedge clk);
    chk("R1 no done after reset", done_cnt, 0);
    chk("R1 ready after reset", int'(in_ready), 1);
  endtask

  initial begin
    t_reset();
    t_single(3'd0, 52, "R3 add");
    t_single(3'd1, 52, "R3 sub");
    t_single(3'd2, 72, "R3 mul");
    t_single(3'd3, 104, "R3 div");
    t_single(3'd4, 106, "R3 sqrt");
    t_single(3'd5, 21, "R3 move");
    t_single(3'd7, 52, "R3 reserved code");
    t_indep();
    t_dep();
    t_move(3'd2, 17, 38, "R6 hidden move");
    t_move(3'd1, 52, 73, "R6 dependent move");
    t_collide();
    t_chain();
    t_drain();
    t_reset_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule